// File: doc/BRIEF.md
# Binary Floating-Point Format Converter

This unit takes one floating-point operand per cycle and re-encodes it in another binary interchange width: half (16-bit), single (32-bit) or double (64-bit). Every operand and every result sits right-aligned in a 64-bit container. The result appears one clock after the operand, together with four exception flags. The flags collect events until reset.

Finite values are rounded to nearest, with ties going to even. Results too large for the destination become infinities. Results too small for its normal range are flushed to zero. A subnormal source is normalized exactly.

The unit takes care over special values, most of all signaling NaNs. Before any payload bits are dropped, the quiet bit is set while the value is still in the wider encoding. A narrowing conversion therefore can never turn a NaN into an infinity, and the sign of the NaN always survives.

Two run-time controls set conventions used by some processor families. One selects a legacy quiet-bit polarity. The other selects an alternative half-precision encoding that has no infinities and no NaNs.

Top module: `fpc_convert`

## Requirements
- R1: Format code 00 selects half precision (1/5/10 bits), 01 selects single (1/8/23) and 10 or 11 selects double (1/11/52). Operands and results are right-aligned in 64 bits. Input bits above the source width are ignored, and result bits above the destination width are zero.
- R2: `out_valid` is high exactly in the cycle after each cycle with `in_valid` high. While `in_valid` is low, `out_data` holds its value.
- R3: A finite value converts with round-to-nearest-even, and `flag_inexact` rises when nonzero bits are discarded. Widening a normal or subnormal value is exact.
- R4: An infinity (all-ones exponent, zero fraction) becomes the destination infinity with the same sign. A zero becomes a zero with the same sign. Neither raises a flag.
- R5: With `nan_legacy`=0, a NaN whose fraction MSB is 0 is signaling. It returns a NaN with the input sign whose fraction is the left-aligned input payload, truncated or zero-extended, with the MSB forced to 1. `flag_invalid` rises.
- R6: With `nan_legacy`=0, narrowing a signaling NaN whose nonzero payload bits all fall in the dropped low part returns a quiet NaN (fraction MSB only) that keeps the input sign. It never returns an infinity.
- R7: With `nan_legacy`=0, a quiet NaN (fraction MSB 1) passes through with its sign and left-aligned payload, and raises no flag.
- R8: With `nan_legacy`=1, fraction MSB 1 means signaling. A signaling NaN becomes the default NaN (all-ones exponent, fraction MSB 0, every other fraction bit 1) with the input sign and raises `flag_invalid`. A quiet NaN passes its truncated payload without a flag; if that payload truncates to zero, the default NaN with the input sign is returned instead.
- R9: If the rounded biased exponent exceeds the destination maximum, the result is an infinity with the input sign, and `flag_overflow` and `flag_inexact` rise.
- R10: If the biased destination exponent before rounding is below 1, the result is a zero with the input sign, and `flag_underflow` and `flag_inexact` rise.
- R11: With `half_alt`=1, a half-precision source with exponent 31 is an ordinary finite number. A half-precision destination has maximum biased exponent 31. In that mode, converting a NaN to half gives a signed zero with `flag_invalid`. An infinity gives signed 0x7FFF with `flag_invalid`. An overflow gives signed 0x7FFF with `flag_overflow` and `flag_inexact`.
- R12: Reset clears `out_valid`, `out_data` and all flags. Each flag stays set from the cycle it rises until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | 64 | Operand, right-aligned |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| nan_legacy | input | 1 | 1: fraction MSB set marks a signaling NaN |
| half_alt | input | 1 | 1: half precision has no infinity or NaN encodings |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Result, right-aligned |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_overflow | output | 1 | Sticky overflow flag |
| flag_underflow | output | 1 | Sticky underflow flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The hardest case to reach is a narrowing signaling NaN whose payload lives entirely in the bits that truncation removes. Random operands almost never produce a NaN with only low payload bits set. The bench therefore builds such operands directly, for both signs and for double-to-single and double-to-half. It also builds the legacy-polarity quiet NaN whose payload truncates to zero. Rounding ties, the largest alternative-half values, and flush boundaries are also set up directly. A random mix of formats and modes then runs against the behavioural model every cycle.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    localparam int CW       = 64;   // container width
    localparam int MW       = 52;   // widest fraction
    localparam int XEW      = 11;   // widest exponent field
    localparam int EXW      = 14;   // signed unbiased exponent
    localparam int ALT_EMAX = 31;   // top biased exponent, alternative half

    localparam logic [1:0] FMT_H = 2'd0;
    localparam logic [1:0] FMT_S = 2'd1;

    typedef enum logic [1:0] {CL_ZERO, CL_FIN, CL_INF, CL_NAN} cls_e;

    typedef struct packed {
        logic                  sign;
        cls_e                  cls;
        logic signed [EXW-1:0] exp;   // unbiased, value = 1.man * 2^exp
        logic [MW-1:0]         man;   // left-aligned fraction or NaN payload
    } unp_t;

    typedef struct packed {
        logic inv;
        logic ovf;
        logic unf;
        logic inx;
    } flg_t;

    function automatic int frac_w(input logic [1:0] c);
        case (c)
            FMT_H:   return 10;
            FMT_S:   return 23;
            default: return 52;
        endcase
    endfunction

    function automatic int exp_w(input logic [1:0] c);
        case (c)
            FMT_H:   return 5;
            FMT_S:   return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int bias_of(input logic [1:0] c);
        return (1 << (exp_w(c) - 1)) - 1;
    endfunction

    function automatic int lead_zeros(input logic [MW-1:0] v);
        int n;
        n = MW;
        for (int i = 0; i < MW; i++) begin
            if (v[i]) n = MW - 1 - i;
        end
        return n;
    endfunction

    function automatic logic [CW-1:0] pack_fp(input logic s, input logic [XEW-1:0] e,
                                              input logic [CW-1:0] f, input logic [1:0] c);
        return (CW'(s) << (frac_w(c) + exp_w(c))) | (CW'(e) << frac_w(c)) | f;
    endfunction
endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack
    import fpc_pkg::*;
(
    input  logic [CW-1:0] in_data,
    input  logic [1:0]    fmt,
    input  logic          half_alt,
    output unp_t          u
);
    int             fw;
    int             ew;
    int             bs;
    int             lz;
    logic [XEW-1:0] ebits;
    logic [MW-1:0]  al;
    logic           special;

    always_comb begin
        fw      = frac_w(fmt);
        ew      = exp_w(fmt);
        bs      = bias_of(fmt);
        ebits   = XEW'((in_data >> fw) & ((64'd1 << ew) - 64'd1));
        al      = MW'((in_data & ((64'd1 << fw) - 64'd1)) << (MW - fw));
        special = (ebits == XEW'((1 << ew) - 1)) && !(half_alt && (fmt == FMT_H));
        lz      = lead_zeros(al);

        u.sign = in_data[6'(fw + ew)];
        u.man  = al;
        u.exp  = '0;
        if (special) begin
            u.cls = (al == '0) ? CL_INF : CL_NAN;
        end else if (ebits == '0 && al == '0) begin
            u.cls = CL_ZERO;
        end else if (ebits == '0) begin
            // subnormal: shift the leading one out into the hidden position
            u.cls = CL_FIN;
            u.exp = EXW'(-bs - lz);
            u.man = al << (lz + 1);
        end else begin
            u.cls = CL_FIN;
            u.exp = EXW'(int'(ebits) - bs);
        end
    end
endmodule

// File: rtl/fpc_nan.sv
module fpc_nan
    import fpc_pkg::*;
(
    input  logic          sign,
    input  logic [MW-1:0] pay,
    input  logic [1:0]    fmt,
    input  logic          legacy,
    input  logic          half_alt,
    output logic [CW-1:0] res,
    output logic          inv
);
    int             fd;
    logic [XEW-1:0] all1;
    logic [CW-1:0]  dflt;
    logic [CW-1:0]  frac;
    logic           snan;

    always_comb begin
        fd   = frac_w(fmt);
        all1 = XEW'((1 << exp_w(fmt)) - 1);
        dflt = (64'd1 << (fd - 1)) - 64'd1;
        snan = legacy ? pay[MW-1] : !pay[MW-1];
        inv  = snan;
        frac = '0;
        if (half_alt && (fmt == FMT_H)) begin
            inv = 1'b1;
            res = pack_fp(sign, '0, '0, fmt);
        end else if (!legacy) begin
            // quieten at full width, then truncate: MSB stays set
            frac = CW'({1'b1, pay[MW-2:0]}) >> (MW - fd);
            res  = pack_fp(sign, all1, frac, fmt);
        end else begin
            frac = snan ? '0 : (CW'(pay) >> (MW - fd));
            if (frac == '0) frac = dflt;
            res = pack_fp(sign, all1, frac, fmt);
        end
    end
endmodule

// File: rtl/fpc_round.sv
module fpc_round
    import fpc_pkg::*;
(
    input  unp_t          u,
    input  logic [1:0]    fmt,
    input  logic          half_alt,
    output logic [CW-1:0] res,
    output flg_t          flg
);
    int            fd;
    int            ed;
    int            eb;
    int            ebr;
    int            emax_b;
    logic          alt_d;
    logic [CW-1:0] wide;
    logic [CW-1:0] keep;
    logic [CW-1:0] sum;
    logic [CW-1:0] low_mask;
    logic          guard;
    logic          stk;
    logic          up;

    always_comb begin
        fd       = frac_w(fmt);
        ed       = exp_w(fmt);
        alt_d    = half_alt && (fmt == FMT_H);
        emax_b   = alt_d ? ALT_EMAX : (1 << ed) - 2;
        eb       = int'(u.exp) + bias_of(fmt);
        wide     = {u.man, {(CW-MW){1'b0}}};
        keep     = wide >> (CW - fd);
        guard    = wide[6'(CW - 1 - fd)];
        low_mask = (64'd1 << (CW - 1 - fd)) - 64'd1;
        stk      = |(wide & low_mask);
        up       = guard & (stk | keep[0]);
        sum      = keep + CW'(up);
        ebr      = eb;
        if (sum == (64'd1 << fd)) begin
            sum = '0;
            ebr = eb + 1;
        end

        res = '0;
        flg = '0;
        case (u.cls)
            CL_ZERO: res = pack_fp(u.sign, '0, '0, fmt);
            CL_INF: begin
                if (alt_d) begin
                    res     = pack_fp(u.sign, XEW'(ALT_EMAX), (64'd1 << fd) - 64'd1, fmt);
                    flg.inv = 1'b1;
                end else begin
                    res = pack_fp(u.sign, XEW'((1 << ed) - 1), '0, fmt);
                end
            end
            CL_FIN: begin
                if (eb < 1) begin
                    res     = pack_fp(u.sign, '0, '0, fmt);
                    flg.unf = 1'b1;
                    flg.inx = 1'b1;
                end else if (ebr > emax_b) begin
                    flg.ovf = 1'b1;
                    flg.inx = 1'b1;
                    if (alt_d) res = pack_fp(u.sign, XEW'(ALT_EMAX), (64'd1 << fd) - 64'd1, fmt);
                    else       res = pack_fp(u.sign, XEW'((1 << ed) - 1), '0, fmt);
                end else begin
                    res     = pack_fp(u.sign, XEW'(ebr), sum, fmt);
                    flg.inx = guard | stk;
                end
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/fpc_convert.sv
module fpc_convert
    import fpc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_data,
    input  logic [1:0]    src_fmt,
    input  logic [1:0]    dst_fmt,
    input  logic          nan_legacy,
    input  logic          half_alt,
    output logic          out_valid,
    output logic [CW-1:0] out_data,
    output logic          flag_invalid,
    output logic          flag_overflow,
    output logic          flag_underflow,
    output logic          flag_inexact
);
    typedef struct packed {
        logic          valid;
        logic [CW-1:0] data;
        flg_t          flg;
    } st_t;

    st_t           st_d, st_q;
    unp_t          unp;
    logic [CW-1:0] nan_res;
    logic          nan_inv;
    logic [CW-1:0] num_res;
    flg_t          num_flg;

    fpc_unpack u_unpack (
        .in_data  (in_data),
        .fmt      (src_fmt),
        .half_alt (half_alt),
        .u        (unp)
    );

    fpc_nan u_nan (
        .sign     (unp.sign),
        .pay      (unp.man),
        .fmt      (dst_fmt),
        .legacy   (nan_legacy),
        .half_alt (half_alt),
        .res      (nan_res),
        .inv      (nan_inv)
    );

    fpc_round u_round (
        .u        (unp),
        .fmt      (dst_fmt),
        .half_alt (half_alt),
        .res      (num_res),
        .flg      (num_flg)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            if (unp.cls == CL_NAN) begin
                st_d.data    = nan_res;
                st_d.flg.inv = st_q.flg.inv | nan_inv;
            end else begin
                st_d.data = num_res;
                st_d.flg  = st_q.flg | num_flg;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.valid;
    assign out_data       = st_q.data;
    assign flag_invalid   = st_q.flg.inv;
    assign flag_overflow  = st_q.flg.ovf;
    assign flag_underflow = st_q.flg.unf;
    assign flag_inexact   = st_q.flg.inx;
endmodule

// File: rtl/fpc_convert_chk.sv
module fpc_convert_chk
    import fpc_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [CW-1:0] in_data,
    input logic [1:0]    src_fmt,
    input logic [1:0]    dst_fmt,
    input logic          nan_legacy,
    input logic          half_alt,
    input logic          out_valid,
    input logic [CW-1:0] out_data,
    input logic          flag_invalid,
    input logic          flag_overflow,
    input logic          flag_underflow,
    input logic          flag_inexact
);
    logic s_snan_in;
    logic d_nan_in;
    assign s_snan_in = (src_fmt == 2'b01) && (in_data[30:23] == 8'hFF) &&
                       (in_data[22:0] != 23'h0) && !in_data[22] && !nan_legacy;
    assign d_nan_in  = (src_fmt == 2'b10) && (dst_fmt == 2'b01) &&
                       (in_data[62:52] == 11'h7FF) && (in_data[51:0] != 52'h0) && !nan_legacy;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_data)); // R2
    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && dst_fmt == 2'b00) |=> (out_data[63:16] == 48'h0)); // R1
    AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && s_snan_in) |=> flag_invalid); // R5
    AST_NARROW_NAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && d_nan_in) |=> (out_data[30:22] == 9'h1FF && out_data[31] == $past(in_data[63]))); // R6
    AST_STICKY_INV: assert property (@(posedge clk) disable iff (!rst_n) flag_invalid |=> flag_invalid); // R12
    AST_STICKY_OVF: assert property (@(posedge clk) disable iff (!rst_n) flag_overflow |=> flag_overflow); // R12
    AST_STICKY_UNF: assert property (@(posedge clk) disable iff (!rst_n) flag_underflow |=> flag_underflow); // R12
    AST_STICKY_INX: assert property (@(posedge clk) disable iff (!rst_n) flag_inexact |=> flag_inexact); // R12
endmodule

bind fpc_convert fpc_convert_chk u_chk (.*);

// File: tb/fpc_convert_bench.sv
module fpc_convert_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [1:0]  src_fmt = '0;
    logic [1:0]  dst_fmt = '0;
    logic        nan_legacy = 1'b0;
    logic        half_alt = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

    int          checks = 0;
    int          failures = 0;
    bit          finished = 0;
    logic [3:0]  mflags = '0;
    logic [63:0] q_data[$];
    logic [3:0]  q_flag[$];
    string       q_tag[$];

    fpc_convert u_fpc_convert (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int bw_frac(input logic [1:0] c);
        return (c == 2'd0) ? 10 : (c == 2'd1) ? 23 : 52;
    endfunction
    function automatic int bw_exp(input logic [1:0] c);
        return (c == 2'd0) ? 5 : (c == 2'd1) ? 8 : 11;
    endfunction
    function automatic logic [63:0] mk(input bit s, input int e, input logic [63:0] f, input logic [1:0] c);
        return (64'(s) << (bw_frac(c) + bw_exp(c))) | (64'(e) << bw_frac(c)) | f;
    endfunction

    // flags {invalid, overflow, underflow, inexact}
    function automatic void model(input logic [63:0] x, input logic [1:0] sf, input logic [1:0] df,
                                  input bit leg, input bit alt,
                                  output logic [63:0] r, output logic [3:0] fl);
        int fw, ew, bs, fd, ed, bd, e, ex, eb, emx, drop;
        logic [63:0] f, sig, keep, rem, half, pay, fr;
        bit s, q, altd;
        fw = bw_frac(sf); ew = bw_exp(sf); bs = (1 << (ew - 1)) - 1;
        fd = bw_frac(df); ed = bw_exp(df); bd = (1 << (ed - 1)) - 1;
        e = int'((x >> fw) & ((64'd1 << ew) - 1));
        f = x & ((64'd1 << fw) - 1);
        s = x[fw + ew];
        altd = alt && (df == 2'd0);
        fl = '0; r = '0;
        if (e == (1 << ew) - 1 && !(alt && sf == 2'd0)) begin
            if (f != 0) begin
                pay = f << (52 - fw);
                q = leg ? !pay[51] : pay[51];
                if (altd) begin
                    r = 64'(s) << 15; fl = 4'b1000;
                end else begin
                    if (!leg) fr = (pay | (64'd1 << 51)) >> (52 - fd);
                    else begin
                        fr = q ? (pay >> (52 - fd)) : 64'd0;
                        if (fr == 0) fr = (64'd1 << (fd - 1)) - 1;
                    end
                    r = mk(s, (1 << ed) - 1, fr, df);
                    if (!q) fl = 4'b1000;
                end
            end else if (altd) begin
                r = mk(s, 31, 64'h3FF, df); fl = 4'b1000;
            end else r = mk(s, (1 << ed) - 1, 0, df);
        end else if (e == 0 && f == 0) begin
            r = mk(s, 0, 0, df);
        end else begin
            sig = (e == 0) ? f : (f | (64'd1 << fw));
            ex = ((e == 0) ? 1 : e) - bs - fw;
            while (sig < (64'd1 << 52)) begin sig = sig << 1; ex--; end
            eb = ex + 52 + bd;
            drop = 52 - fd;
            emx = altd ? 31 : (1 << ed) - 2;
            if (eb < 1) begin
                r = mk(s, 0, 0, df); fl = 4'b0011;
            end else begin
                keep = sig >> drop;
                rem = sig & ((64'd1 << drop) - 1);
                half = (drop > 0) ? (64'd1 << (drop - 1)) : 64'd0;
                if (drop > 0 && (rem > half || (rem == half && keep[0]))) keep = keep + 1;
                if (keep == (64'd1 << (fd + 1))) begin keep = keep >> 1; eb++; end
                if (eb > emx) begin
                    fl = 4'b0101;
                    r = altd ? mk(s, 31, 64'h3FF, df) : mk(s, (1 << ed) - 1, 0, df);
                end else begin
                    r = mk(s, eb, keep & ((64'd1 << fd) - 1), df);
                    if (rem != 0) fl[0] = 1'b1;
                end
            end
        end
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic send(input logic [63:0] x, input logic [1:0] sf, input logic [1:0] df,
                        input bit leg, input bit alt, input string tag);
        logic [63:0] r;
        logic [3:0]  fl;
        model(x, sf, df, leg, alt, r, fl);
        mflags = mflags | fl;
        in_data = x; src_fmt = sf; dst_fmt = df; nan_legacy = leg; half_alt = alt;
        in_valid = 1'b1;
        q_data.push_back(r); q_flag.push_back(mflags); q_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R2 unexpected out_valid", {63'b0, out_valid}, 64'd0);
            end else begin
                logic [63:0] ed;
                logic [3:0]  ef;
                string       tg;
                ed = q_data.pop_front(); ef = q_flag.pop_front(); tg = q_tag.pop_front();
                check(out_data === ed, {tg, " data"}, out_data, ed);
                check({flag_invalid, flag_overflow, flag_underflow, flag_inexact} === ef,
                      {tg, " flags"}, 64'({flag_invalid, flag_overflow, flag_underflow, flag_inexact}), 64'(ef));
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == 1'b0 && out_data == 64'd0, "R12 reset outputs", out_data, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({flag_invalid, flag_overflow, flag_underflow, flag_inexact} == 4'd0, "R12 reset flags",
              64'({flag_invalid, flag_overflow, flag_underflow, flag_inexact}), 64'd0);

        // R2: latency and idle behaviour
        send(64'h3F80_0000, 2'd1, 2'd2, 0, 0, "R2");
        check(out_valid == 1'b1, "R2 valid one cycle later", {63'b0, out_valid}, 64'd1);
        @(negedge clk);
        check(out_valid == 1'b0, "R2 valid drops", {63'b0, out_valid}, 64'd0);

        // R1: container handling
        send(64'hDEAD_BEEF_3F80_0000, 2'd1, 2'd2, 0, 0, "R1 upper input ignored");
        send(64'h4000_0000_0000_0000, 2'd3, 2'd0, 0, 0, "R1 code 11 double");
        send(64'hFFFF_FFFF_FFFF_3C00, 2'd0, 2'd1, 0, 0, "R1 half source");

        // R4: infinities and zeros
        send(64'h7F80_0000, 2'd1, 2'd0, 0, 0, "R4 +inf");
        send(64'hFFF0_0000_0000_0000, 2'd2, 2'd1, 0, 0, "R4 -inf");
        send(64'h8000, 2'd0, 2'd2, 0, 0, "R4 -zero");

        // R7: quiet NaNs, standard polarity
        send(64'h7FC1_2345, 2'd1, 2'd2, 0, 0, "R7 widen qnan");
        send(64'hFFF8_0000_0000_0ABC, 2'd2, 2'd0, 0, 0, "R7 narrow qnan");

        // R3: finite values and rounding (all exact or inexact only)
        send(64'h4009_21FB_5444_2D18, 2'd2, 2'd1, 0, 0, "R3 pi to single");
        send(64'h4009_21FB_5444_2D18, 2'd2, 2'd0, 0, 0, "R3 pi to half");
        send(64'h0001, 2'd0, 2'd1, 0, 0, "R3 half subnormal widen");
        send(64'h0000_0000_0040_0001, 2'd1, 2'd2, 0, 0, "R3 single subnormal widen");
        send(64'h3F80_1000, 2'd1, 2'd0, 0, 0, "R3 tie to even down");
        send(64'h3F80_3000, 2'd1, 2'd0, 0, 0, "R3 tie to even up");
        send(64'h3F80_0001, 2'd1, 2'd0, 0, 0, "R3 inexact only");

        // R5 / R6: signaling NaNs, standard polarity
        send(64'h7F80_0001, 2'd1, 2'd2, 0, 0, "R5 widen snan");
        send(64'hFFA0_0000, 2'd1, 2'd0, 0, 0, "R5 narrow snan payload");
        send(64'h7FF0_0000_0000_0001, 2'd2, 2'd1, 0, 0, "R6 low payload to single");
        send(64'hFFF0_0000_0000_0001, 2'd2, 2'd0, 0, 0, "R6 negative low payload to half");

        // R8: legacy polarity
        send(64'h7FC0_0000, 2'd1, 2'd2, 1, 0, "R8 legacy snan");
        send(64'h7F80_0001, 2'd1, 2'd0, 1, 0, "R8 legacy qnan truncates to zero");
        send(64'hFF90_0000, 2'd1, 2'd0, 1, 0, "R8 legacy qnan payload");
        send(64'h7FF0_0000_0000_0100, 2'd2, 2'd2, 1, 0, "R8 legacy qnan same width");

        // R9 / R10: range limits
        send(64'h7E37_E43C_8800_759C, 2'd2, 2'd1, 0, 0, "R9 overflow to single");
        send(64'hFF7F_FFFF, 2'd1, 2'd0, 0, 0, "R9 single max to half");
        send(64'h01A5_6E1F_C2F8_F359, 2'd2, 2'd1, 0, 0, "R10 flush to zero");
        send(64'h8000_0000_3300_0000, 2'd1, 2'd0, 0, 0, "R10 tiny to half");

        // R11: alternative half
        send(64'h7C00, 2'd0, 2'd1, 0, 1, "R11 exp31 finite");
        send(64'hFFFF, 2'd0, 2'd2, 0, 1, "R11 largest alt half");
        send(64'hFFC0_0000, 2'd1, 2'd0, 0, 1, "R11 nan to alt half");
        send(64'h7F80_0000, 2'd1, 2'd0, 0, 1, "R11 inf to alt half");
        send(64'h4880_0000, 2'd1, 2'd0, 0, 1, "R11 overflow alt half");
        send(64'h47C3_5000, 2'd1, 2'd0, 0, 1, "R11 large fits alt half");

        // R12: sticky flags survive clean traffic
        send(64'h3F80_0000, 2'd1, 2'd2, 0, 0, "R12 sticky after clean op");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] x;
            x = {$urandom, $urandom};
            if (i % 4 == 0) x[62:52] = 11'h7FF;
            if (i % 5 == 0) x[30:23] = 8'hFF;
            if (i % 6 == 0) x[14:10] = 5'h1F;
            send(x, 2'($urandom % 4), 2'($urandom % 4), 1'($urandom), 1'($urandom), "R3 random mix");
        end

        // R12: reset clears sticky flags
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({flag_invalid, flag_overflow, flag_underflow, flag_inexact} == 4'd0 && out_valid == 1'b0,
              "R12 flags cleared by reset", 64'({flag_invalid, flag_overflow, flag_underflow, flag_inexact}), 64'd0);
        rst_n = 1'b1;
        mflags = '0;
        @(negedge clk);
        send(64'h3C00, 2'd0, 2'd2, 0, 0, "R12 after reset");
        repeat (3) @(negedge clk);
        check(q_data.size() == 0, "R2 all results returned", 64'(q_data.size()), 64'd0);
        finish_run();
    end
endmodule